// File: doc/BRIEF.md
# Branch Condition and Loop Evaluator

This block decides, within one combinational pass, whether a short relative jump or a counted loop instruction transfers control. It takes a five-bit selector, the five status flags produced by an earlier compare or arithmetic step (carry, zero, sign, overflow, parity), the count register, the current instruction pointer and a signed byte displacement. It returns a taken bit, the instruction pointer to use next, and the count register value to write back.

The selector's upper bit splits two families. With the upper bit clear, the low four bits name one of sixteen flag predicates. The even codes test a base predicate and the odd code that follows is its negation. With the upper bit set, the low bits pick a count-based form: a jump on a zero count, a plain loop, or a loop qualified by the zero flag. Decode, fetch and flag generation sit outside the block, and so do far transfers. The block drives no flag.

Top module: `branch_loop_eval`

## Requirements
- R1: Unsigned predicates: code 2 (below) is taken when carry=1, code 3 (above-or-equal) when carry=0, code 6 (below-or-equal) when carry=1 or zero=1, code 7 (above) when carry=0 and zero=0.
- R2: Signed predicates: code 12 (less) is taken when sign differs from overflow, code 13 (greater-or-equal) when they match, code 14 (less-or-equal) when they differ or zero=1, code 15 (greater) when they match and zero=0.
- R3: Single-flag predicates: codes 0/1 take overflow at 1/0, codes 4/5 zero at 1/0, codes 8/9 sign at 1/0, codes 10/11 parity at 1/0.
- R4: Selector 5'b10011 (jump on zero count) is taken exactly when the count input is 0, and the count output equals the count input.
- R5: Selector 5'b10010 (plain loop) outputs the count minus one, modulo 2^16, and is taken when that new count is nonzero. An input of 0 gives 16'hFFFF and is taken.
- R6: Selector 5'b10001 (loop while equal) is taken when the decremented count is nonzero and zero=1. Selector 5'b10000 (loop while not equal) is taken when the decremented count is nonzero and zero=0. Both output the decremented count.
- R7: When taken, the next pointer is the current pointer plus the sign-extended displacement, modulo 2^16.
- R8: When not taken, the next pointer equals the current pointer.
- R9: For every selector with the upper bit clear, the count output equals the count input.
- R10: Selectors 5'b10100 through 5'b11111 are reserved. They are never taken, and they leave the count output equal to the count input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | 5 | Condition/loop selector |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| cx_in | input | 16 | Current count register |
| ip_in | input | 16 | Current instruction pointer |
| disp | input | 8 | Signed relative displacement |
| taken | output | 1 | Transfer decision |
| next_ip | output | 16 | Pointer to use next |
| cx_out | output | 16 | Count register write-back value |

## Verification
The bench builds the block with its defaults: a 16-bit pointer and count and an 8-bit displacement. At these widths, directed vectors can reach the wraps that matter: a pointer near 16'hFFFF with a positive displacement, a pointer near zero with a negative one, and loop counts of 0, 1 and 2, where the decrement either wraps or lands on zero. Random selectors and flag combinations cover all sixteen predicates with both polarities, and every reserved code is driven directly.

// File: rtl/branch_loop_pkg.sv
package branch_loop_pkg;
  localparam int SEL_W = 5;

  typedef enum logic [1:0] {
    CNT_LOOP_NZ = 2'd0,
    CNT_LOOP_Z  = 2'd1,
    CNT_LOOP    = 2'd2,
    CNT_JZERO   = 2'd3
  } cnt_form_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic o;
    logic p;
  } flags_t;

  // Base predicate for a pair of condition codes (code[3:1]).
  function automatic logic base_pred(input logic [2:0] pair, input flags_t f);
    logic r;
    case (pair)
      3'd0: r = f.o;
      3'd1: r = f.c;
      3'd2: r = f.z;
      3'd3: r = f.c | f.z;
      3'd4: r = f.s;
      3'd5: r = f.p;
      3'd6: r = f.s ^ f.o;
      default: r = (f.s ^ f.o) | f.z;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bl_cond_eval.sv
module bl_cond_eval
  import branch_loop_pkg::*;
(
  input  logic [3:0] code,
  input  flags_t     flags,
  output logic       cond_true
);
  logic base;
  always_comb begin
    base      = base_pred(code[3:1], flags);
    cond_true = base ^ code[0];
  end
endmodule

// File: rtl/bl_count_unit.sv
module bl_count_unit
  import branch_loop_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             active,
  input  logic [1:0]       form,
  input  logic             zf,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cnt_next,
  output logic             cnt_take
);
  logic [CNT_W-1:0] dec;
  logic             dec_nz;
  logic             cnt_zero;

  always_comb begin
    dec      = cnt_in - CNT_W'(1);
    dec_nz   = |dec;
    cnt_zero = ~|cnt_in;
    cnt_next = cnt_in;
    cnt_take = 1'b0;
    if (active) begin
      case (cnt_form_e'(form))
        CNT_LOOP_NZ: begin cnt_next = dec; cnt_take = dec_nz & ~zf; end
        CNT_LOOP_Z:  begin cnt_next = dec; cnt_take = dec_nz & zf;  end
        CNT_LOOP:    begin cnt_next = dec; cnt_take = dec_nz;       end
        default:     begin cnt_take = cnt_zero;                     end
      endcase
    end
  end
endmodule

// File: rtl/bl_target_calc.sv
module bl_target_calc #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] ip_cur,
  input  logic [DISP_W-1:0] offset,
  output logic [ADDR_W-1:0] ip_target
);
  localparam int EXT_W = ADDR_W - DISP_W;
  logic [ADDR_W-1:0] ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext = {{EXT_W{offset[DISP_W-1]}}, offset};
    end else begin : g_trunc
      assign ext = offset[ADDR_W-1:0];
    end
  endgenerate

  assign ip_target = ip_cur + ext;
endmodule

// File: rtl/branch_loop_eval.sv
module branch_loop_eval
  import branch_loop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [4:0]        sel,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic              flag_s,
  input  logic              flag_o,
  input  logic              flag_p,
  input  logic [ADDR_W-1:0] cx_in,
  input  logic [ADDR_W-1:0] ip_in,
  input  logic [DISP_W-1:0] disp,
  output logic              taken,
  output logic [ADDR_W-1:0] next_ip,
  output logic [ADDR_W-1:0] cx_out
);
  flags_t            flags;
  logic              is_count_form;
  logic              is_reserved;
  logic              cond_true;
  logic              cnt_take;
  logic [ADDR_W-1:0] branch_target;

  assign flags         = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o, p: flag_p};
  assign is_count_form = sel[4] & ~|sel[3:2];
  assign is_reserved   = sel[4] & |sel[3:2];

  bl_cond_eval u_cond (
    .code      (sel[3:0]),
    .flags     (flags),
    .cond_true (cond_true)
  );

  bl_count_unit #(.CNT_W(ADDR_W)) u_count (
    .active   (is_count_form),
    .form     (sel[1:0]),
    .zf       (flag_z),
    .cnt_in   (cx_in),
    .cnt_next (cx_out),
    .cnt_take (cnt_take)
  );

  bl_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_target (
    .ip_cur    (ip_in),
    .offset    (disp),
    .ip_target (branch_target)
  );

  always_comb begin
    if (!sel[4])          taken = cond_true;
    else if (is_reserved) taken = 1'b0;
    else                  taken = cnt_take;
    next_ip = taken ? branch_target : ip_in;
  end
endmodule

// File: rtl/branch_loop_eval_chk.sv
module branch_loop_eval_chk #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input logic [4:0]        sel,
  input logic [ADDR_W-1:0] cx_in,
  input logic [ADDR_W-1:0] ip_in,
  input logic [DISP_W-1:0] disp,
  input logic              taken,
  input logic [ADDR_W-1:0] next_ip,
  input logic [ADDR_W-1:0] cx_out,
  input logic [ADDR_W-1:0] branch_target,
  input logic              is_count_form
);
  logic [ADDR_W-1:0] sdisp;
  assign sdisp = ADDR_W'($signed(disp));

  always_comb begin
    if (!$isunknown({sel, cx_in, ip_in, disp})) begin
      assert_hold_ip_R8: assert (taken || next_ip == ip_in)
        else $error("R8 pointer moved without a transfer");
      assert_target_R7: assert (!taken || next_ip == ip_in + sdisp)
        else $error("R7 wrong target");
      assert_cx_keep_R9: assert (sel[4] || cx_out == cx_in)
        else $error("R9 count changed by flag predicate");
      assert_reserved_R10: assert (!(sel[4] && |sel[3:2]) || (!taken && cx_out == cx_in))
        else $error("R10 reserved code acted");
      assert_loop_dec_R5: assert (!(is_count_form && sel[1:0] != 2'b11) || cx_out == cx_in - ADDR_W'(1))
        else $error("R5 loop count not decremented");
      assert_loop_nz_R6: assert (!(is_count_form && sel[1:0] != 2'b11 && taken) || cx_out != '0)
        else $error("R6 loop taken on zero count");
      assert_jzero_R4: assert (!(sel == 5'b10011) || (taken == (cx_in == '0) && cx_out == cx_in))
        else $error("R4 zero-count jump wrong");
      assert_adder_R7: assert (branch_target == ip_in + sdisp)
        else $error("R7 adder mismatch");
    end
  end
endmodule

bind branch_loop_eval branch_loop_eval_chk #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_chk (
  .sel           (sel),
  .cx_in         (cx_in),
  .ip_in         (ip_in),
  .disp          (disp),
  .taken         (taken),
  .next_ip       (next_ip),
  .cx_out        (cx_out),
  .branch_target (branch_target),
  .is_count_form (is_count_form)
);

// File: tb/branch_loop_eval_tb.sv
`timescale 1ns/1ps
module branch_loop_eval_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  sel;
  logic        fc, fz, fs, fo, fp;
  logic [15:0] cx_in, ip_in;
  logic [7:0]  disp;
  logic        taken;
  logic [15:0] next_ip, cx_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  branch_loop_eval u_dut (
    .sel(sel), .flag_c(fc), .flag_z(fz), .flag_s(fs), .flag_o(fo), .flag_p(fp),
    .cx_in(cx_in), .ip_in(ip_in), .disp(disp),
    .taken(taken), .next_ip(next_ip), .cx_out(cx_out)
  );

  function automatic string req_of(input logic [4:0] s);
    if (s[4] && s[3:2] != 2'b00) return "R10";
    case (s)
      5'b10011: return "R4";
      5'b10010: return "R5";
      5'b10001, 5'b10000: return "R6";
      5'd2, 5'd3, 5'd6, 5'd7: return "R1";
      5'd12, 5'd13, 5'd14, 5'd15: return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [15:0] exp_cx(input logic [4:0] s, input logic [15:0] c);
    if (s == 5'b10000 || s == 5'b10001 || s == 5'b10010) return c - 16'd1;
    return c;
  endfunction

  function automatic logic exp_taken(input logic [4:0] s, input logic c, z, sg, o, p,
                                     input logic [15:0] cx);
    logic [15:0] nc;
    nc = cx - 16'd1;
    case (s)
      5'd0:  return o;
      5'd1:  return !o;
      5'd2:  return c;
      5'd3:  return !c;
      5'd4:  return z;
      5'd5:  return !z;
      5'd6:  return c || z;
      5'd7:  return !c && !z;
      5'd8:  return sg;
      5'd9:  return !sg;
      5'd10: return p;
      5'd11: return !p;
      5'd12: return sg != o;
      5'd13: return sg == o;
      5'd14: return (sg != o) || z;
      5'd15: return (sg == o) && !z;
      5'b10000: return (nc != 0) && !z;
      5'b10001: return (nc != 0) && z;
      5'b10010: return nc != 0;
      5'b10011: return cx == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [4:0] s, input logic [4:0] f,
                       input logic [15:0] c, input logic [15:0] ip, input logic [7:0] d);
    logic et;
    logic [15:0] eip, ecx;
    int delta;
    @(negedge clk);
    sel = s; {fc, fz, fs, fo, fp} = f; cx_in = c; ip_in = ip; disp = d;
    #1;
    et    = exp_taken(s, f[4], f[3], f[2], f[1], f[0], c);
    delta = (d >= 8'd128) ? int'(d) - 256 : int'(d);
    eip   = et ? 16'(int'(ip) + delta) : ip;  // R7 / R8
    ecx   = exp_cx(s, c);                     // R9 keeps count on predicates
    n_vec++;
    if (taken !== et || next_ip !== eip || cx_out !== ecx) begin
      n_bad++;
      $display("FAIL %s sel=%b: taken/ip/cx got %b/%h/%h expected %b/%h/%h",
               req_of(s), s, taken, next_ip, cx_out, et, eip, ecx);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    // reset-style idle vector: predicate 0 with all flags clear
    apply(5'd0, 5'b00000, 16'h1234, 16'h0100, 8'h05);
    // R3 each single-flag code, each polarity
    for (int k = 0; k < 32; k++) apply(5'(k % 16), 5'(k), 16'h0007, 16'h2000, 8'h10);
    // R1 / R2 exhaustive flag combinations over the compound codes
    for (int f = 0; f < 32; f++) begin
      apply(5'd6, 5'(f), 16'h0003, 16'h4000, 8'hF0);
      apply(5'd7, 5'(f), 16'h0003, 16'h4000, 8'hF0);
      apply(5'd14, 5'(f), 16'h0003, 16'h4000, 8'h7F);
      apply(5'd15, 5'(f), 16'h0003, 16'h4000, 8'h7F);
    end
    // R4 zero-count jump
    apply(5'b10011, 5'b00000, 16'h0000, 16'h0300, 8'h04);
    apply(5'b10011, 5'b11111, 16'h0001, 16'h0300, 8'h04);
    // R5 loop boundaries: 0 wraps and is taken, 1 ends, 2 continues
    apply(5'b10010, 5'b00000, 16'h0000, 16'h0500, 8'hFE);
    apply(5'b10010, 5'b00000, 16'h0001, 16'h0500, 8'hFE);
    apply(5'b10010, 5'b00000, 16'h0002, 16'h0500, 8'hFE);
    // R6 qualified loops with both zero-flag values
    apply(5'b10001, 5'b01000, 16'h0005, 16'h0600, 8'hFA);
    apply(5'b10001, 5'b00000, 16'h0005, 16'h0600, 8'hFA);
    apply(5'b10000, 5'b00000, 16'h0005, 16'h0600, 8'hFA);
    apply(5'b10000, 5'b01000, 16'h0005, 16'h0600, 8'hFA);
    apply(5'b10001, 5'b01000, 16'h0001, 16'h0600, 8'hFA);
    // R7 pointer wrap both directions
    apply(5'd4, 5'b01000, 16'h0000, 16'hFFF0, 8'h20);
    apply(5'd4, 5'b01000, 16'h0000, 16'h0010, 8'h80);
    // R10 every reserved selector
    for (int r = 20; r < 32; r++) apply(5'(r), 5'b11111, 16'h0000, 16'h0700, 8'h08);
    // random mix
    for (int i = 0; i < 3000; i++)
      apply(5'($urandom_range(0, 31)), 5'($urandom), 16'($urandom_range(0, 3) == 0 ? $urandom_range(0, 2) : $urandom),
            16'($urandom), 8'($urandom));
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule